// File: doc/BRIEF.md
# Serial SAR Converter Read Controller

This block runs on the system clock and reads a 16-bit successive-approximation converter over a three-wire link. It drives an active-low chip select (`csN`) and a serial clock (`sclk`), and it takes serial data in on `sdi`. The serial clock comes from a divider. The `halfPeriod` input sets how many system cycles each clock phase lasts. That value is clamped so that both phases stay long enough and the clock never runs slower than the converter allows.

A start request lowers chip select. The controller then clocks through the converter's sampling preamble without using the data it carries, and checks the null bit that must read zero. After that it shifts in 3 to 16 result bits, most significant bit first. Once the last wanted bit is in, it raises chip select, which stops the conversion early when fewer than 16 bits are requested. The result comes out left-aligned with a one-cycle valid strobe. For full 16-bit reads an optional mode keeps clocking through the converter's least-significant-bit-first replay and compares it against the word already captured.

Right after reset the controller runs one conversion on its own and throws the result away. This leaves the converter in power-down. Start requests that arrive while a frame is running are held and served once chip select has been high for at least one serial clock period.

Top module: `sadc_reader`

## Requirements
- R1: Every high phase and every low phase of `sclk` while `csN` is low lasts exactly H system cycles. H is `halfPeriod` clamped to the range MIN_HALF (10) to MAX_HALF (1041) and is latched when the frame starts.
- R2: When `csN` is high, `sclk` is low. `csN` falls while `sclk` is low, and after reset `csN` is high and `resultValid` is low.
- R3: `sdi` is sampled in the system cycle in which `sclk` rises. The values at the first five rising edges of a frame are ignored.
- R4: The bit sampled at the sixth rising edge is the null bit. If it reads 1, `frameError` is 1 in the cycle of `resultValid` and stays until the next result. Otherwise it is 0.
- R5: Result bits are taken at rising edges 7 through 6+N, MSB first. N is `bitCount` clamped to 3..16 and latched at frame start. Without replay a frame has exactly 6+N rising edges, and `csN` rises together with the `sclk` fall that ends the last high phase.
- R6: `result[15:16-N]` holds the N captured bits and the lower bits are zero. `resultValid` is high for exactly one cycle, the cycle in which `csN` has just risen.
- R7: With `checkReplay` = 1 and N = 16, the frame runs 15 more rising edges (37 in total). The bit at rising edge 22+k (k = 1..15) is compared with result bit k, and any mismatch sets `replayError` alongside `resultValid`. With N < 16, `checkReplay` has no effect: the edge count stays 6+N and `replayError` stays 0.
- R8: After reset, the controller runs one frame of 22 rising edges without any request and produces no `resultValid` for it.
- R9: A `startReq` seen while a frame or its gap is in progress is held. The next frame starts only after `csN` has been high for at least 2*H system cycles.
- R10: A `startReq` sampled while the controller is idle drives `csN` low at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request one conversion read |
| bitCount | input | 5 | Number of result bits wanted (clamped 3..16) |
| checkReplay | input | 1 | Capture and compare the LSB-first replay on 16-bit reads |
| halfPeriod | input | 11 | System cycles per serial clock phase (clamped) |
| sdi | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| busy | output | 1 | A frame or its trailing gap is in progress |
| result | output | 16 | Left-aligned conversion result |
| resultValid | output | 1 | One-cycle strobe marking a new result |
| frameError | output | 1 | Null bit was not zero in the last result |
| replayError | output | 1 | Replay did not match the last 16-bit result |

## Verification
The bench models the converter at the pin level. The bit counts it requests lie below 3, above 16 and in between, so a design that skipped the clamp would either give a truncated or misaligned word or keep clocking after the converter stops. Half periods below the minimum and above the maximum are tried as well, since a missing clamp would break the phase-length check. The bench corrupts single replay bits on full reads and on short reads. A comparator that ignored the bit count would report a false `replayError`, and one with the wrong index would miss the error or flag a good word. A request that arrives mid-frame must be served after a gap of full length, and the discarded power-on frame must not raise `resultValid`.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
  localparam int RES_W = 16;
  localparam int IDX_W = $clog2(RES_W);

  typedef struct packed {
    logic             frameStart;
    logic             nullSmp;
    logic             dataSmp;
    logic             replaySmp;
    logic [IDX_W-1:0] replayIdx;
    logic             done;
    logic             dummy;
  } ctlStrobe_t;
endpackage

// File: rtl/sadc_ctl.sv
module sadc_ctl
  import sadc_pkg::*;
#(
  parameter int HALF_W   = 11,
  parameter int MIN_HALF = 10,
  parameter int MAX_HALF = 1041,
  parameter int PRE_CLKS = 5,
  parameter int CNT_W    = $clog2(RES_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [CNT_W-1:0]  bitCount,
  input  logic              checkReplay,
  input  logic [HALF_W-1:0] halfPeriod,
  output logic              csN,
  output logic              sclk,
  output logic              busy,
  output logic [CNT_W-1:0]  nBits,
  output ctlStrobe_t        strobe
);
  localparam int RISE_W = $clog2(PRE_CLKS + 2 * RES_W + 1);
  localparam int DIV_W  = HALF_W + 1;
  localparam logic [RISE_W-1:0] NULL_RISE   = RISE_W'(PRE_CLKS + 1);
  localparam logic [RISE_W-1:0] REPLAY_BASE = RISE_W'(PRE_CLKS + 1 + RES_W);
  localparam logic [RISE_W-1:0] MAX_RISE    = RISE_W'(PRE_CLKS + 2 * RES_W);
  localparam logic [CNT_W-1:0]  MIN_BITS    = CNT_W'(3);
  localparam logic [CNT_W-1:0]  MAX_BITS    = CNT_W'(RES_W);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP} ctlState_t;

  ctlState_t          state;
  logic [DIV_W-1:0]   divCnt;
  logic [RISE_W-1:0]  riseCnt;
  logic [HALF_W-1:0]  halfLat;
  logic [CNT_W-1:0]   nLat;
  logic               replayLat;
  logic               dummyLat;
  logic               dummyPend;
  logic               pendReq;

  logic [HALF_W-1:0]  halfEff;
  logic [CNT_W-1:0]   nEff;
  logic               launch;
  logic               lowEnd;
  logic               highEnd;
  logic               gapEnd;
  logic [RISE_W-1:0]  nextRise;
  logic [RISE_W-1:0]  lastRise;

  always_comb begin
    halfEff = halfPeriod;
    if (halfPeriod < HALF_W'(MIN_HALF)) halfEff = HALF_W'(MIN_HALF);
    else if (halfPeriod > HALF_W'(MAX_HALF)) halfEff = HALF_W'(MAX_HALF);
    nEff = bitCount;
    if (bitCount < MIN_BITS) nEff = MIN_BITS;
    else if (bitCount > MAX_BITS) nEff = MAX_BITS;
  end

  assign launch   = (state == ST_IDLE) && (dummyPend || pendReq || startReq);
  assign lowEnd   = (state == ST_LOW)  && ((divCnt + 1'b1) == {1'b0, halfLat});
  assign highEnd  = (state == ST_HIGH) && ((divCnt + 1'b1) == {1'b0, halfLat});
  assign gapEnd   = (state == ST_GAP)  && ((divCnt + 1'b1) == {halfLat, 1'b0});
  assign nextRise = riseCnt + 1'b1;
  assign lastRise = replayLat ? MAX_RISE : (NULL_RISE + RISE_W'(nLat));

  always_comb begin
    strobe            = '0;
    strobe.frameStart = launch;
    strobe.nullSmp    = lowEnd && (nextRise == NULL_RISE);
    strobe.dataSmp    = lowEnd && (nextRise > NULL_RISE) &&
                        (nextRise <= NULL_RISE + RISE_W'(nLat));
    strobe.replaySmp  = lowEnd && replayLat && (nextRise > REPLAY_BASE);
    strobe.replayIdx  = IDX_W'(nextRise - REPLAY_BASE);
    strobe.done       = highEnd && (riseCnt == lastRise);
    strobe.dummy      = dummyLat;
  end

  assign busy  = (state != ST_IDLE);
  assign nBits = nLat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      csN       <= 1'b1;
      sclk      <= 1'b0;
      divCnt    <= '0;
      riseCnt   <= '0;
      halfLat   <= HALF_W'(MIN_HALF);
      nLat      <= MAX_BITS;
      replayLat <= 1'b0;
      dummyLat  <= 1'b0;
      dummyPend <= 1'b1;
      pendReq   <= 1'b0;
    end else begin
      // request bookkeeping: the power-on frame never swallows a user request
      if (launch && dummyPend) begin
        dummyPend <= 1'b0;
        pendReq   <= pendReq | startReq;
      end else if (launch) begin
        pendReq <= 1'b0;
      end else if (startReq) begin
        pendReq <= 1'b1;
      end

      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            state     <= ST_LOW;
            csN       <= 1'b0;
            sclk      <= 1'b0;
            divCnt    <= '0;
            riseCnt   <= '0;
            halfLat   <= halfEff;
            nLat      <= dummyPend ? MAX_BITS : nEff;
            replayLat <= !dummyPend && checkReplay && (nEff == MAX_BITS);
            dummyLat  <= dummyPend;
          end
        end
        ST_LOW: begin
          if (lowEnd) begin
            state   <= ST_HIGH;
            sclk    <= 1'b1;
            divCnt  <= '0;
            riseCnt <= nextRise;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (highEnd) begin
            sclk   <= 1'b0;
            divCnt <= '0;
            if (riseCnt == lastRise) begin
              state <= ST_GAP;
              csN   <= 1'b1;
            end else begin
              state <= ST_LOW;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (gapEnd) begin
            state  <= ST_IDLE;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sadc_dp.sv
module sadc_dp
  import sadc_pkg::*;
#(
  parameter int CNT_W = $clog2(RES_W + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdi,
  input  ctlStrobe_t       strobe,
  input  logic [CNT_W-1:0] nBits,
  output logic [RES_W-1:0] result,
  output logic             resultValid,
  output logic             frameError,
  output logic             replayError
);
  logic [RES_W-1:0] shiftReg;
  logic             nullBad;
  logic             replayBad;
  logic [RES_W-1:0] aligned;

  assign aligned = shiftReg << (CNT_W'(RES_W) - nBits);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg    <= '0;
      nullBad     <= 1'b0;
      replayBad   <= 1'b0;
      result      <= '0;
      resultValid <= 1'b0;
      frameError  <= 1'b0;
      replayError <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (strobe.frameStart) begin
        shiftReg  <= '0;
        nullBad   <= 1'b0;
        replayBad <= 1'b0;
      end
      if (strobe.nullSmp) nullBad <= sdi;
      if (strobe.dataSmp) shiftReg <= {shiftReg[RES_W-2:0], sdi};
      if (strobe.replaySmp && (sdi != shiftReg[strobe.replayIdx])) replayBad <= 1'b1;
      if (strobe.done && !strobe.dummy) begin
        result      <= aligned;
        resultValid <= 1'b1;
        frameError  <= nullBad;
        replayError <= replayBad;
      end
    end
  end
endmodule

// File: rtl/sadc_reader.sv
module sadc_reader
  import sadc_pkg::*;
#(
  parameter int HALF_W   = 11,
  parameter int MIN_HALF = 10,
  parameter int MAX_HALF = 1041,
  parameter int PRE_CLKS = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [4:0]        bitCount,
  input  logic              checkReplay,
  input  logic [HALF_W-1:0] halfPeriod,
  input  logic              sdi,
  output logic              csN,
  output logic              sclk,
  output logic              busy,
  output logic [RES_W-1:0]  result,
  output logic              resultValid,
  output logic              frameError,
  output logic              replayError
);
  localparam int CNT_W = 5;

  ctlStrobe_t       strobe;
  logic [CNT_W-1:0] nBits;

  sadc_ctl #(
    .HALF_W(HALF_W), .MIN_HALF(MIN_HALF), .MAX_HALF(MAX_HALF),
    .PRE_CLKS(PRE_CLKS), .CNT_W(CNT_W)
  ) uCtl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .bitCount(bitCount),
    .checkReplay(checkReplay), .halfPeriod(halfPeriod),
    .csN(csN), .sclk(sclk), .busy(busy), .nBits(nBits), .strobe(strobe)
  );

  sadc_dp #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .sdi(sdi), .strobe(strobe), .nBits(nBits),
    .result(result), .resultValid(resultValid),
    .frameError(frameError), .replayError(replayError)
  );
endmodule

// File: rtl/sadc_reader_chk.sv
module sadc_reader_chk #(
  parameter int MIN_HALF = 10
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic resultValid
);
  logic [15:0] runLen;
  logic [15:0] csHighCnt;
  logic        prevSclk;
  logic        prevCsN;
  logic        seenFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen    <= '0;
      csHighCnt <= '0;
      prevSclk  <= 1'b0;
      prevCsN   <= 1'b1;
      seenFrame <= 1'b0;
    end else begin
      prevSclk <= sclk;
      prevCsN  <= csN;
      if ((sclk != prevSclk) || (csN != prevCsN)) runLen <= 16'd1;
      else if (runLen != 16'hFFFF) runLen <= runLen + 1'b1;
      if (!csN) begin
        csHighCnt <= '0;
        seenFrame <= 1'b1;
      end else if (csHighCnt != 16'hFFFF) begin
        csHighCnt <= csHighCnt + 1'b1;
      end
    end
  end

  a_r1_min_phase: assert property (@(posedge clk) disable iff (!rstN)
    ((sclk != prevSclk) && !prevCsN) |-> (runLen >= 16'(MIN_HALF)));

  a_r2_idle_low: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  a_r2_select_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> !sclk);

  a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  a_r6_with_select: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (csN && $past(!csN)));

  a_r9_gap: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(csN) && seenFrame) |-> (csHighCnt >= 16'(2 * MIN_HALF)));
endmodule

bind sadc_reader sadc_reader_chk #(.MIN_HALF(MIN_HALF)) uChk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .resultValid(resultValid)
);

// File: tb/sadc_reader_test.sv
module sadc_reader_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0;
  logic [4:0]  bitCount = 5'd16;
  logic        checkReplay = 1'b0;
  logic [10:0] halfPeriod = 11'd10;
  logic        sdi = 1'b1;
  logic        csN, sclk, busy, resultValid, frameError, replayError;
  logic [15:0] result;

  int testCnt = 0;
  int failCnt = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sadc_reader uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .bitCount(bitCount),
    .checkReplay(checkReplay), .halfPeriod(halfPeriod), .sdi(sdi),
    .csN(csN), .sclk(sclk), .busy(busy), .result(result),
    .resultValid(resultValid), .frameError(frameError), .replayError(replayError)
  );

  // converter model
  logic [15:0] mWord = 16'h0;
  logic        mNullBad = 1'b0;
  int          mCorrupt = 0;
  int          fcnt = 0;
  int          rcnt = 0;

  always @(negedge csN) begin
    fcnt = 0;
    rcnt = 0;
    sdi  = 1'b1;
  end

  always @(posedge sclk) if (!csN) rcnt++;

  always @(negedge sclk) begin
    if (!csN) begin
      fcnt++;
      if (fcnt == 5) sdi = mNullBad;
      else if (fcnt >= 6 && fcnt <= 21) sdi = mWord[21 - fcnt];
      else if (fcnt >= 22 && fcnt <= 36) sdi = mWord[fcnt - 21] ^ (mCorrupt == fcnt - 21);
      else sdi = 1'b1;
    end
  end

  // phase-length monitor
  int   expHalf = 10;
  int   runLen = 0;
  int   phaseBad = 0;
  logic prevSclk = 1'b0;
  logic prevCs = 1'b1;
  int   validCnt = 0;

  always @(negedge clk) begin
    cycles++;
    if (resultValid) validCnt++;
    if ((sclk !== prevSclk) || (csN !== prevCs)) begin
      if (prevCs === 1'b0 && runLen != expHalf) phaseBad++;
      runLen = 1;
    end else begin
      runLen++;
    end
    prevSclk = sclk;
    prevCs   = csN;
  end

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int clampHalf(input int h);
    if (h < 10) return 10;
    if (h > 1041) return 1041;
    return h;
  endfunction

  function automatic int clampBits(input int n);
    if (n < 3) return 3;
    if (n > 16) return 16;
    return n;
  endfunction

  function automatic logic [15:0] expResult(input logic [15:0] w, input int n);
    logic [15:0] mask;
    mask = 16'hFFFF << (16 - n);
    return w & mask;
  endfunction

  task automatic waitValid();
    int t = 0;
    while (!resultValid && t < 150000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic doFrame(input logic [15:0] w, input int n, input logic rep,
                         input int half, input logic nb, input int corrupt);
    int  nE;
    int  expRise;
    logic expRep;
    nE = clampBits(n);
    expRep = rep && (nE == 16) && (corrupt != 0);
    expRise = 6 + nE + ((rep && nE == 16) ? 15 : 0);
    mWord = w; mNullBad = nb; mCorrupt = corrupt;
    bitCount = 5'(n); checkReplay = rep; halfPeriod = 11'(half);
    expHalf = clampHalf(half);
    phaseBad = 0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk("R10 csN low after idle request", csN == 1'b0, csN, 0);
    waitValid();
    chk("R5/R6 left-aligned result", result == expResult(w, nE), result, expResult(w, nE));
    chk("R4 frameError", frameError == nb, frameError, nb);
    chk("R7 replayError", replayError == expRep, replayError, expRep);
    chk("R5 rising edge count", rcnt == expRise, rcnt, expRise);
    chk("R1 phase length", phaseBad == 0, phaseBad, 0);
    @(negedge clk);
    chk("R6 valid pulse width", resultValid == 1'b0, resultValid, 0);
    waitIdle();
  endtask

  // watchdog
  initial begin
    while (cycles < 190000) @(negedge clk);
    failCnt++;
    testCnt++;
    $display("FAIL watchdog actual=%0d expected=<190000", cycles);
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    int gapLen;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk("R2 reset csN", csN == 1'b1, csN, 1);
    chk("R2 reset sclk", sclk == 1'b0, sclk, 0);
    chk("R2 reset valid", resultValid == 1'b0, resultValid, 0);
    rstN = 1'b1;

    // R8: power-on dummy frame
    while (csN) @(negedge clk);
    while (!csN) @(negedge clk);
    chk("R8 dummy rising edges", rcnt == 22, rcnt, 22);
    chk("R8 dummy no valid", validCnt == 0, validCnt, 0);
    waitIdle();

    // directed
    doFrame(16'hA5C3, 16, 1'b0, 10, 1'b0, 0);          // R3 R5 full read
    doFrame(16'h8001, 16, 1'b0, 3, 1'b0, 0);           // R1 low clamp
    doFrame(16'hF0F0, 0, 1'b0, 12, 1'b0, 0);           // R5 bit count clamp low
    doFrame(16'h1234, 20, 1'b0, 12, 1'b0, 0);          // R5 bit count clamp high
    doFrame(16'hBEEF, 8, 1'b0, 11, 1'b1, 0);           // R4 bad null bit
    doFrame(16'h5A3C, 16, 1'b1, 10, 1'b0, 0);          // R7 clean replay
    doFrame(16'h5A3C, 16, 1'b1, 10, 1'b0, 7);          // R7 corrupt bit 7
    doFrame(16'hC001, 16, 1'b1, 10, 1'b0, 15);         // R7 corrupt top bit
    doFrame(16'h7777, 8, 1'b1, 10, 1'b0, 3);           // R7 ignored when short
    doFrame(16'hFFFF, 3, 1'b0, 2000, 1'b0, 0);         // R1 high clamp

    // R9: request during a frame is held
    mWord = 16'h6C39; mNullBad = 1'b0; mCorrupt = 0;
    bitCount = 5'd12; checkReplay = 1'b0; halfPeriod = 11'd15; expHalf = 15;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (100) @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitValid();
    chk("R9 first result", result == expResult(16'h6C39, 12), result, expResult(16'h6C39, 12));
    gapLen = 0;
    while (csN && gapLen < 1000) begin
      @(negedge clk);
      gapLen++;
    end
    chk("R9 gap at least two phases", gapLen >= 30 && gapLen <= 32, gapLen, 31);
    waitValid();
    chk("R9 held request served", result == expResult(16'h6C39, 12), result, expResult(16'h6C39, 12));
    waitIdle();
    chk("R9 no extra frame", busy == 1'b0, busy, 0);

    // random
    for (int i = 0; i < 20; i++) begin
      logic [15:0] w;
      int n, h, c;
      logic r, nb;
      w  = 16'($urandom);
      n  = $urandom_range(1, 18);
      h  = $urandom_range(5, 24);
      r  = 1'($urandom_range(0, 1));
      nb = ($urandom_range(0, 5) == 0);
      c  = ($urandom_range(0, 2) == 0) ? $urandom_range(1, 15) : 0;
      doFrame(w, n, r, h, nb, c);
    end

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule